// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, side A and side B. Each side has its own storage register, and that register samples its own bus on the rising edge of a dedicated capture clock. One direction at a time can be driven. The data sent onto the driven bus is either the live value of the opposite bus or the stored copy of it, and each direction has its own selector for this choice.

The block has no internal tri-state. Each bus is modeled as an input, an output and an output-enable, and any tri-state resolution happens outside the block. An active-low output enable isolates both sides. A direction input picks which side is driven. Register capture never depends on the enable or the direction, so a register can load while the block is driving its bus from the other side.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `cap_a_clk_i`, the A-side register loads `a_i`.
- R2: On each rising edge of `cap_b_clk_i`, the B-side register loads `b_i`.
- R3: Capture happens at every capture edge for any value of `oe_ni` and `dir_b_i`, including while the other side is being driven.
- R4: While `oe_ni` is 1, `a_oe_o` and `b_oe_o` are both 0, and `a_o` and `b_o` are both 0.
- R5: While `oe_ni` is 0, `dir_b_i`=1 gives `b_oe_o`=1 and `a_oe_o`=0, and `dir_b_i`=0 gives `a_oe_o`=1 and `b_oe_o`=0. A bus that is not driven outputs 0.
- R6: While B is driven and `sel_ab_i`=0 (live), `b_o` equals `a_i` combinationally.
- R7: While B is driven and `sel_ab_i`=1 (stored), `b_o` equals the A-side register. It shows a new capture as soon as that capture edge has occurred.
- R8: While A is driven, `sel_ba_i`=0 gives `a_o` = `b_i`, and `sel_ba_i`=1 gives `a_o` = the B-side register, updated right after a capture edge.
- R9: `sel_ba_i` has no effect while `dir_b_i`=1, and `sel_ab_i` has no effect while `dir_b_i`=0. Changing a selector with no clock edge switches the output between live and stored data at once.
- R10: Driving `rst_ni` low clears both registers to 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset of both registers |
| cap_a_clk_i | input | 1 | Capture clock for the A-side register |
| cap_b_clk_i | input | 1 | Capture clock for the B-side register |
| oe_ni | input | 1 | Active-low output enable; 1 isolates both buses |
| dir_b_i | input | 1 | 1: drive B from A side; 0: drive A from B side |
| sel_ab_i | input | 1 | Source for B: 0 live A bus, 1 A-side register |
| sel_ba_i | input | 1 | Source for A: 0 live B bus, 1 B-side register |
| a_i | input | 8 | A bus value as seen at the pins |
| a_o | output | 8 | Data driven onto A bus |
| a_oe_o | output | 1 | Drive enable for A bus |
| b_i | input | 8 | B bus value as seen at the pins |
| b_o | output | 8 | Data driven onto B bus |
| b_oe_o | output | 1 | Drive enable for B bus |

## Verification
The registers can only be seen at the ports through stored mode. A wrong captured value therefore stays hidden until the selector for that direction chooses stored data with the matching direction enabled. From then on it appears at once on the driven output, with no clock edge needed. For this reason the bench switches into stored mode right after each capture, including captures made under isolation or while the other direction is driven. It also toggles the selectors between clock edges, so that a register that is stale or loaded from the wrong side shows up in the same cycle.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/bxr_cap_reg.sv
module bxr_cap_reg #(
  parameter int unsigned W = bxr_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // loads on every edge; no enable by design
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/bxr_dir_ctl.sv
module bxr_dir_ctl (
  input  logic oe_ni,
  input  logic dir_b_i,
  output logic a_oe_o,
  output logic b_oe_o
);
  always_comb begin
    a_oe_o = 1'b0;
    b_oe_o = 1'b0;
    if (!oe_ni) begin
      if (dir_b_i) b_oe_o = 1'b1;
      else         a_oe_o = 1'b1;
    end
  end
endmodule

// File: rtl/bxr_out_mux.sv
module bxr_out_mux #(
  parameter int unsigned W = bxr_pkg::DATA_W
) (
  input  logic          en_i,
  input  bxr_pkg::src_e src_i,
  input  logic [W-1:0]  live_i,
  input  logic [W-1:0]  stored_i,
  output logic [W-1:0]  d_o
);
  always_comb begin
    d_o = '0;
    if (en_i) d_o = (src_i == bxr_pkg::SRC_STORED) ? stored_i : live_i;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int unsigned W = bxr_pkg::DATA_W
) (
  input  logic         rst_ni,
  input  logic         cap_a_clk_i,
  input  logic         cap_b_clk_i,
  input  logic         oe_ni,
  input  logic         dir_b_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  localparam int unsigned NSIDE = 2; // 0: A side, 1: B side

  logic [W-1:0] bus_in  [NSIDE];
  logic [W-1:0] reg_q   [NSIDE];
  logic [W-1:0] drv_d   [NSIDE];
  logic         cap_clk [NSIDE];
  logic         drv_en  [NSIDE];
  bxr_pkg::src_e src    [NSIDE];

  assign bus_in[0]  = a_i;
  assign bus_in[1]  = b_i;
  assign cap_clk[0] = cap_a_clk_i;
  assign cap_clk[1] = cap_b_clk_i;
  // side s is driven from the opposite side's data
  assign src[0] = bxr_pkg::src_e'(sel_ba_i);
  assign src[1] = bxr_pkg::src_e'(sel_ab_i);

  bxr_dir_ctl i_dir (
    .oe_ni  (oe_ni),
    .dir_b_i(dir_b_i),
    .a_oe_o (drv_en[0]),
    .b_oe_o (drv_en[1])
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    bxr_cap_reg #(.W(W)) i_reg (
      .clk_i (cap_clk[s]),
      .rst_ni(rst_ni),
      .d_i   (bus_in[s]),
      .q_o   (reg_q[s])
    );
    bxr_out_mux #(.W(W)) i_mux (
      .en_i    (drv_en[s]),
      .src_i   (src[s]),
      .live_i  (bus_in[NSIDE-1-s]),
      .stored_i(reg_q[NSIDE-1-s]),
      .d_o     (drv_d[s])
    );
  end

  assign a_o    = drv_d[0];
  assign b_o    = drv_d[1];
  assign a_oe_o = drv_en[0];
  assign b_oe_o = drv_en[1];
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         rst_ni,
  input logic         cap_a_clk_i,
  input logic         cap_b_clk_i,
  input logic         oe_ni,
  input logic         dir_b_i,
  input logic         sel_ab_i,
  input logic         sel_ba_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] a_o,
  input logic [W-1:0] b_o,
  input logic         a_oe_o,
  input logic         b_oe_o,
  input logic [W-1:0] ra,
  input logic [W-1:0] rb
);
  assert_cap_a_R1: assert property (@(posedge cap_a_clk_i) disable iff (!rst_ni)
    1'b1 |=> ra == $past(a_i));
  assert_cap_b_R2: assert property (@(posedge cap_b_clk_i) disable iff (!rst_ni)
    1'b1 |=> rb == $past(b_i));

  always_comb begin
    if (rst_ni) begin
      assert_iso_R4: assert (!oe_ni || (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0));
      assert_dir_R5: assert (oe_ni || (b_oe_o == dir_b_i && a_oe_o == !dir_b_i));
      assert_onehot_R5: assert ($onehot0({a_oe_o, b_oe_o}));
      assert_b_src_R7: assert (!b_oe_o || b_o == (sel_ab_i ? ra : a_i));
      assert_a_src_R8: assert (!a_oe_o || a_o == (sel_ba_i ? rb : b_i));
    end
  end
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) i_chk (
  .rst_ni     (rst_ni),
  .cap_a_clk_i(cap_a_clk_i),
  .cap_b_clk_i(cap_b_clk_i),
  .oe_ni      (oe_ni),
  .dir_b_i    (dir_b_i),
  .sel_ab_i   (sel_ab_i),
  .sel_ba_i   (sel_ba_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .a_o        (a_o),
  .b_o        (b_o),
  .a_oe_o     (a_oe_o),
  .b_oe_o     (b_oe_o),
  .ra         (reg_q[0]),
  .rb         (reg_q[1])
);

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic rst_ni = 1'b0, cap_a = 1'b0, cap_b = 1'b0;
  logic oe_ni = 1'b1, dir_b = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, a_o, b_o;
  logic a_oe, b_oe;

  bus_xcvr_reg #(.W(W)) i_bus_xcvr_reg (
    .rst_ni(rst_ni), .cap_a_clk_i(cap_a), .cap_b_clk_i(cap_b),
    .oe_ni(oe_ni), .dir_b_i(dir_b), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe),
    .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe)
  );

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_ra = '0, m_rb = '0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_b();
    if (oe_ni || !dir_b) return '0;
    return sel_ab ? m_ra : a_i;
  endfunction
  function automatic logic [W-1:0] exp_a();
    if (oe_ni || dir_b) return '0;
    return sel_ba ? m_rb : b_i;
  endfunction

  task automatic check_all(string tag);
    chk({tag, " R5 b_oe"}, b_oe, !oe_ni && dir_b);
    chk({tag, " R5 a_oe"}, a_oe, !oe_ni && !dir_b);
    chk({tag, " R6/R7 b_o"}, b_o, exp_b());
    chk({tag, " R8 a_o"}, a_o, exp_a());
  endtask

  task automatic pulse(bit pa, bit pb);
    #1;
    if (pa) begin cap_a = 1'b1; m_ra = a_i; end
    if (pb) begin cap_b = 1'b1; m_rb = b_i; end
    #1;
    cap_a = 1'b0; cap_b = 1'b0;
  endtask

  task automatic settle(); #1; endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0646));
    // R10: reset state seen through stored mode
    a_i = 8'h5a; b_i = 8'ha5;
    oe_ni = 0; dir_b = 1; sel_ab = 1; settle();
    chk("R10 b_o stored after reset", b_o, 0);
    dir_b = 0; sel_ba = 1; settle();
    chk("R10 a_o stored after reset", a_o, 0);
    @(posedge clk); rst_ni = 1;

    // R4 and R3: capture while isolated
    @(posedge clk); oe_ni = 1; a_i = 8'h3c; b_i = 8'hc3; pulse(1, 1);
    settle();
    chk("R4 a_oe", a_oe, 0); chk("R4 b_oe", b_oe, 0);
    chk("R4 a_o", a_o, 0);   chk("R4 b_o", b_o, 0);
    a_i = 8'h11; b_i = 8'h22;
    oe_ni = 0; dir_b = 1; sel_ab = 1; settle();
    chk("R3 R7 isolated capture A", b_o, 8'h3c);
    dir_b = 0; sel_ba = 1; settle();
    chk("R3 R8 isolated capture B", a_o, 8'hc3);

    // R3: capture A while A is being driven (dir A)
    @(posedge clk); dir_b = 0; sel_ba = 0; a_i = 8'h77; b_i = 8'h99; pulse(1, 0);
    settle(); chk("R8 live b->a", a_o, 8'h99);
    dir_b = 1; sel_ab = 1; settle();
    chk("R3 capture A under opposite dir", b_o, 8'h77);
    // R7: stored output follows immediately after edge
    @(posedge clk); a_i = 8'he1; pulse(1, 0); settle();
    chk("R7 immediate stored update", b_o, 8'he1);

    // R9: selector toggles without edges
    @(posedge clk); a_i = 8'h0f; b_i = 8'hf0; dir_b = 1; sel_ab = 0; settle();
    chk("R9 R6 live", b_o, 8'h0f);
    sel_ab = 1; settle(); chk("R9 stored no edge", b_o, 8'he1);
    sel_ba = ~sel_ba; settle(); chk("R9 sel_ba ignored dir B", b_o, 8'he1);
    chk("R9 a_o quiet", a_o, 0);
    dir_b = 0; sel_ba = 0; settle(); chk("R9 live b", a_o, 8'hf0);
    sel_ab = 0; settle(); chk("R9 sel_ab ignored dir A", a_o, 8'hf0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      @(posedge clk);
      {oe_ni, dir_b, sel_ab, sel_ba} = 4'($urandom);
      a_i = W'($urandom); b_i = W'($urandom);
      pulse(($urandom % 3) == 0, ($urandom % 3) == 0);
      settle(); check_all("rand R1 R2 R3");
      a_i = W'($urandom); b_i = W'($urandom);
      settle(); check_all("rand R6 R8");
    end

    // R10: async reset mid-run
    @(posedge clk); oe_ni = 0; dir_b = 1; sel_ab = 1; #1 rst_ni = 0; m_ra = '0; m_rb = '0;
    settle(); chk("R10 async clear A", b_o, 0);
    dir_b = 0; sel_ba = 1; settle(); chk("R10 async clear B", a_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule